// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is a bus-attached serial port for 8-bit characters. Software reaches it through seven 32-bit word registers on a simple select/write bus. Bytes written for transmission wait in a small FIFO until the transmitter sends them. Bytes recovered from the receive line wait in a second FIFO until software reads them. Each character frame holds one low start bit, eight data bits sent least significant bit first, no parity, and one or two high stop bits. The length of each bit is set by a 16-bit divisor: one bit lasts `DIV + 1` clock cycles.

The block does not raise an interrupt for each character. Each direction compares its FIFO level against a programmable watermark count. The live result of that comparison is visible in a read-only pending register. The single interrupt output is the OR of the pending bits that are enabled. On the data registers, bit 31 reports FIFO full (transmit side) or FIFO empty (receive side). A single read of the receive data register therefore returns the status, the byte and the dequeue together.

The receiver waits for a falling edge on the synchronised line. It then takes a majority vote of three samples around the middle of each bit, so a short low glitch is rejected as a false start. A frame whose stop bit reads low is discarded. The receiver needs a divisor of at least 3.

Top module: `wmark_uart`

## Requirements
- R1: After reset, TXCTRL (offset 0x08), RXCTRL (0x0C), IE (0x10) and IP (0x14) read as zero, DIV (0x18) reads 15, the serial output is high and the interrupt output is low.
- R2: A write to TXDATA (0x00) enqueues bits 7:0 into an 8-entry transmit FIFO. A read of TXDATA returns bit 31 set exactly when that FIFO is full. A byte written while the FIFO is full is dropped and never sent.
- R3: Each transmitted frame is a low start bit, eight data bits least significant bit first, and then high stop bits: one stop bit when TXCTRL bit 1 is 0, two when it is 1. Each bit lasts DIV+1 clock cycles.
- R4: No frame starts while TXCTRL bit 0 is 0. Queued bytes are kept and are sent in write order once the bit is set.
- R5: A read of RXDATA (0x04) returns the oldest received byte in bits 7:0 with bit 31 clear, and removes that byte. When the receive FIFO is empty, the read returns exactly 0x8000_0000 and removes nothing.
- R6: While RXCTRL bit 0 is 0, frames on the receive line are ignored and nothing enters the receive FIFO.
- R7: A low pulse too short to survive the mid-bit majority vote is rejected as a false start. A frame whose stop bit samples low is discarded. The receiver then accepts the next valid frame.
- R8: A byte received while the 8-entry receive FIFO is full is discarded, and the 8 stored bytes are kept in arrival order.
- R9: IP bit 0 is 1 exactly while the transmit FIFO level is below TXCTRL bits 18:16.
- R10: IP bit 1 is 1 exactly while the receive FIFO level is above RXCTRL bits 18:16. A count of 0 asserts it as soon as one byte is stored.
- R11: IP is read-only, and a write to it changes nothing. IE bits 1:0 read back as written.
- R12: The interrupt output equals the OR over both bits of (IE AND IP). With IE zero it stays low.
- R13: DIV holds the low 16 bits of a write. The upper write bits are dropped and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| tx_o | output | 1 | Serial transmit line, idle high |
| rx_i | input | 1 | Serial receive line, asynchronous |
| irq_o | output | 1 | Combined watermark interrupt |

## Verification
The transmit path is tried with a full FIFO burst plus one overflow write, with single bytes under one and two stop bits, and with a short divisor. Each frame is compared bit by bit against a behavioural line model, which separates timing errors, bit-order errors and errors in the dropped byte. The receive path is fed clean frames, frames while disabled, a one-cycle glitch, a low stop bit and a nine-frame overflow burst. Each of these has a different correct outcome in the receive FIFO. The watermark and interrupt logic is probed at counts where the pending bit should and should not flip, which separates off-by-one compare faults from masking faults.

// File: rtl/wmark_uart_pkg.sv
package wmark_uart_pkg;

   localparam int BUS_W  = 32;
   localparam int ADDR_W = 5;
   localparam int CHAR_W = 8;

   // Register byte offsets
   localparam logic [ADDR_W-1:0] OFF_TXDATA = 5'h00;
   localparam logic [ADDR_W-1:0] OFF_RXDATA = 5'h04;
   localparam logic [ADDR_W-1:0] OFF_TXCTRL = 5'h08;
   localparam logic [ADDR_W-1:0] OFF_RXCTRL = 5'h0C;
   localparam logic [ADDR_W-1:0] OFF_IE     = 5'h10;
   localparam logic [ADDR_W-1:0] OFF_IP     = 5'h14;
   localparam logic [ADDR_W-1:0] OFF_DIV    = 5'h18;

   // Field positions software relies on
   localparam int FLAG_BIT = 31;
   localparam int EN_BIT   = 0;
   localparam int STOP_BIT = 1;
   localparam int WM_LSB   = 16;
   localparam int IRQ_TX   = 0;
   localparam int IRQ_RX   = 1;

   typedef enum logic {RX_IDLE, RX_FRAME} rx_state_e;

endpackage

// File: rtl/wmark_fifo.sv
module wmark_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   // R2 / R8: a push into a full FIFO leaves the level unchanged
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (count == $past(count)));

   // R5: a pop of an empty FIFO leaves the level unchanged
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (count == '0));

endmodule

// File: rtl/wmark_tx.sv
module wmark_tx #(
   parameter int DIV_W  = 16,
   parameter int CHAR_W = 8,
   localparam int FRAME_W = CHAR_W + 3,
   localparam int IDX_W   = $clog2(FRAME_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              two_stop,
   input  logic [DIV_W-1:0]  div,
   input  logic              fifo_empty,
   input  logic [CHAR_W-1:0] fifo_data,
   output logic              fifo_pop,
   output logic              tx_o
);

   logic [FRAME_W-1:0] shreg;
   logic [DIV_W-1:0]   cyc;
   logic [IDX_W-1:0]   bidx, last_idx;
   logic               busy, start;

   assign start    = !busy && en && !fifo_empty;
   assign fifo_pop = start;
   assign tx_o     = shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '1;
         cyc      <= '0;
         bidx     <= '0;
         last_idx <= '0;
         busy     <= 1'b0;
      end else if (start) begin
         shreg    <= {2'b11, fifo_data, 1'b0};
         cyc      <= '0;
         bidx     <= '0;
         last_idx <= two_stop ? IDX_W'(CHAR_W + 2) : IDX_W'(CHAR_W + 1);
         busy     <= 1'b1;
      end else if (busy) begin
         if (cyc == div) begin
            cyc   <= '0;
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            if (bidx == last_idx) busy <= 1'b0;
            else                  bidx <= bidx + IDX_W'(1);
         end else begin
            cyc <= cyc + DIV_W'(1);
         end
      end
   end

   // R3: every frame begins with a low start bit
   p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !tx_o);

   // R4: while disabled and idle, no frame begins
   p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !en) |=> !busy);

   // R3: the line is high whenever the serialiser is idle
   p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx_o);

endmodule

// File: rtl/wmark_rx.sv
module wmark_rx
   import wmark_uart_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int CHAR_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W = $clog2(CHAR_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [DIV_W-1:0]  div,
   input  logic              rx_i,
   output logic              push,
   output logic [CHAR_W-1:0] data
);

   logic [SYNC_STAGES-1:0] sync;
   logic                   rx_s, rx_prev;
   rx_state_e              state;
   logic [DIV_W-1:0]       cyc, half;
   logic [IDX_W-1:0]       bidx;
   logic [1:0]             ones;
   logic                   in_window, decide, vote;

   // Synchroniser chain, length chosen by parameter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync <= '1;
      else        sync <= {sync[SYNC_STAGES-2:0], rx_i};
   end
   assign rx_s = sync[SYNC_STAGES-1];

   assign half      = div >> 1;
   assign decide    = (cyc == half + DIV_W'(1));
   assign in_window = (cyc == half - DIV_W'(1)) || (cyc == half);
   assign vote      = ({1'b0, ones} + {2'b00, rx_s}) >= 3'd2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_prev <= 1'b1;
         state   <= RX_IDLE;
         cyc     <= '0;
         bidx    <= '0;
         ones    <= '0;
         data    <= '0;
         push    <= 1'b0;
      end else begin
         rx_prev <= rx_s;
         push    <= 1'b0;
         if (!en) begin
            state <= RX_IDLE;
         end else if (state == RX_IDLE) begin
            if (rx_prev && !rx_s) begin
               state <= RX_FRAME;
               cyc   <= DIV_W'(1);
               bidx  <= '0;
               ones  <= '0;
            end
         end else begin
            if (cyc == div) begin
               cyc  <= '0;
               ones <= '0;
               bidx <= bidx + IDX_W'(1);
            end else begin
               cyc <= cyc + DIV_W'(1);
            end
            if (in_window) ones <= ones + {1'b0, rx_s};
            if (decide) begin
               if (bidx == '0) begin
                  if (vote) state <= RX_IDLE;
               end else if (bidx == IDX_W'(CHAR_W + 1)) begin
                  push  <= vote;
                  state <= RX_IDLE;
               end else begin
                  data <= {vote, data[CHAR_W-1:1]};
               end
            end
         end
      end
   end

   // R6: a disabled receiver delivers nothing
   p_rx_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !push);

   // R7: a byte is only delivered on leaving a frame
   p_push_ends_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (state == RX_IDLE));

endmodule

// File: rtl/wmark_uart.sv
module wmark_uart
   import wmark_uart_pkg::*;
#(
   parameter int FIFO_DEPTH  = 8,
   parameter int DIV_W       = 16,
   parameter int WM_W        = 3,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_INIT    = 15,
   parameter bit IRQ_REG     = 1'b0,
   localparam int CW = $clog2(FIFO_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              tx_o,
   input  logic              rx_i,
   output logic              irq_o
);

   // Elaboration-time parameter checks
   if (FIFO_DEPTH != (1 << $clog2(FIFO_DEPTH))) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two");
   end
   if (WM_W >= CW || WM_LSB + WM_W > FLAG_BIT) begin : g_bad_wm
      $error("WM_W does not fit the FIFO level or the register");
   end
   if (DIV_W > WM_LSB) begin : g_bad_div
      $error("DIV_W exceeds the divisor field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DIV_INIT < 3 || DIV_INIT >= (1 << DIV_W)) begin : g_bad_init
      $error("DIV_INIT out of range");
   end

   logic              tx_en, two_stop, rx_en;
   logic [WM_W-1:0]   tx_wm, rx_wm;
   logic [1:0]        ie_q, ip;
   logic [DIV_W-1:0]  div_q;
   logic              wr_any, tx_push, rx_pop, tx_pop, rx_push;
   logic [CHAR_W-1:0] tx_head, rx_head, rx_byte;
   logic [CW-1:0]     tx_count, rx_count;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic              unused_bits;

   assign unused_bits = ^{bus_wdata[BUS_W-1:WM_LSB+WM_W], rx_full};

   assign wr_any  = bus_sel && bus_wr;
   assign tx_push = wr_any && (bus_addr == OFF_TXDATA);
   assign rx_pop  = bus_sel && !bus_wr && (bus_addr == OFF_RXDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en    <= 1'b0;
         two_stop <= 1'b0;
         tx_wm    <= '0;
         rx_en    <= 1'b0;
         rx_wm    <= '0;
         ie_q     <= '0;
         div_q    <= DIV_W'(DIV_INIT);
      end else if (wr_any) begin
         case (bus_addr)
            OFF_TXCTRL: begin
               tx_en    <= bus_wdata[EN_BIT];
               two_stop <= bus_wdata[STOP_BIT];
               tx_wm    <= bus_wdata[WM_LSB +: WM_W];
            end
            OFF_RXCTRL: begin
               rx_en <= bus_wdata[EN_BIT];
               rx_wm <= bus_wdata[WM_LSB +: WM_W];
            end
            OFF_IE:  ie_q  <= bus_wdata[1:0];
            OFF_DIV: div_q <= bus_wdata[DIV_W-1:0];
            default: ;
         endcase
      end
   end

   wmark_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .wdata(bus_wdata[CHAR_W-1:0]),
      .pop(tx_pop), .rdata(tx_head),
      .count(tx_count), .full(tx_full), .empty(tx_empty)
   );

   wmark_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .wdata(rx_byte),
      .pop(rx_pop), .rdata(rx_head),
      .count(rx_count), .full(rx_full), .empty(rx_empty)
   );

   wmark_tx #(.DIV_W(DIV_W), .CHAR_W(CHAR_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(tx_en), .two_stop(two_stop),
      .div(div_q), .fifo_empty(tx_empty), .fifo_data(tx_head),
      .fifo_pop(tx_pop), .tx_o(tx_o)
   );

   wmark_rx #(.DIV_W(DIV_W), .CHAR_W(CHAR_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .div(div_q),
      .rx_i(rx_i), .push(rx_push), .data(rx_byte)
   );

   // Live watermark comparisons
   assign ip[IRQ_TX] = int'(tx_count) < int'(tx_wm);
   assign ip[IRQ_RX] = int'(rx_count) > int'(rx_wm);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFF_TXDATA: bus_rdata[FLAG_BIT] = tx_full;
         OFF_RXDATA: begin
            bus_rdata[FLAG_BIT] = rx_empty;
            if (!rx_empty) bus_rdata[CHAR_W-1:0] = rx_head;
         end
         OFF_TXCTRL: begin
            bus_rdata[EN_BIT]            = tx_en;
            bus_rdata[STOP_BIT]          = two_stop;
            bus_rdata[WM_LSB +: WM_W]    = tx_wm;
         end
         OFF_RXCTRL: begin
            bus_rdata[EN_BIT]            = rx_en;
            bus_rdata[WM_LSB +: WM_W]    = rx_wm;
         end
         OFF_IE:  bus_rdata[1:0]       = ie_q;
         OFF_IP:  bus_rdata[1:0]       = ip;
         OFF_DIV: bus_rdata[DIV_W-1:0] = div_q;
         default: ;
      endcase
   end

   // Interrupt output: combinational or registered variant
   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(ie_q & ip);
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = |(ie_q & ip);
      // R12: with both enables clear the output stays low
      p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (ie_q == 2'b00) |-> !irq_o);
   end

   // R10: a zero receive count flags any stored byte
   p_rxwm_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_wm == '0) && !rx_empty) |-> ip[IRQ_RX]);

   // R13: the divisor changes only on a write to its offset
   p_div_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_any && (bus_addr == OFF_DIV)) |=> $stable(div_q));

   // R9: an empty transmit FIFO with a nonzero count is always flagged
   p_txwm_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && (tx_wm != '0)) |-> ip[IRQ_TX]);

endmodule

// File: tb/tb_wmark_uart.sv
module tb_wmark_uart;

   localparam logic [4:0] A_TXD = 5'h00, A_RXD = 5'h04, A_TXC = 5'h08,
                          A_RXC = 5'h0C, A_IE = 5'h10, A_IP = 5'h14,
                          A_DIV = 5'h18;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        tx_o, irq_o;
   logic        rx_line = 1'b1;

   wmark_uart dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_o(tx_o), .rx_i(rx_line), .irq_o(irq_o)
   );

   always #4 clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0;

   // Behavioural model state
   int   cur_div = 15;
   int   mon_nbits = 10;
   bit   rx_en_m = 0;
   logic [7:0] tx_exp[$];
   logic [7:0] rx_exp[$];

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic rd_check(input string req, input string what,
                           input logic [4:0] a, input logic [31:0] exp);
      logic [31:0] v;
      bus_read(a, v);
      check(req, what, v, exp);
   endtask

   task automatic tx_put(input logic [7:0] b, input bit accepted);
      bus_write(A_TXD, {24'h0, b});
      if (accepted) tx_exp.push_back(b);
   endtask

   task automatic send_rx(input logic [7:0] b, input bit good_stop);
      for (int i = 0; i < 10; i++) begin
         rx_line = (i == 0) ? 1'b0 : (i == 9) ? good_stop : b[i-1];
         repeat (cur_div + 1) @(negedge clk);
      end
      rx_line = 1'b1;
      repeat (4) @(negedge clk);
      if (good_stop && rx_en_m && rx_exp.size() < 8) rx_exp.push_back(b);
   endtask

   task automatic rx_pop_check(input string req);
      logic [7:0] e;
      if (rx_exp.size() == 0) rd_check(req, "rxdata empty", A_RXD, 32'h8000_0000);
      else begin
         e = rx_exp.pop_front();
         rd_check(req, "rxdata byte", A_RXD, {24'h0, e});
      end
   endtask

   // Cycle-by-cycle transmit line model
   bit         mon_active = 0, mon_err = 0;
   int         mon_k = 0, frames_done = 0;
   logic [7:0] mon_byte = 0;

   function automatic logic exp_bit(input int k, input logic [7:0] b);
      int idx = k / (cur_div + 1);
      if (idx == 0) return 1'b0;
      if (idx <= 8) return b[idx-1];
      return 1'b1;
   endfunction

   always @(negedge clk) begin
      if (!rst_n) mon_active = 0;
      else if (mon_active) begin
         if (tx_o !== exp_bit(mon_k, mon_byte)) mon_err = 1;
         mon_k++;
         if (mon_k == mon_nbits * (cur_div + 1)) begin
            mon_active = 0;
            frames_done++;
            checks++;
            if (mon_err) begin
               fails++;
               $display("FAIL R3 frame of byte %h: line deviated, expected %0d bits of %0d cycles",
                        mon_byte, mon_nbits, cur_div + 1);
            end
         end
      end else if (tx_o === 1'b0) begin
         if (tx_exp.size() == 0) begin
            checks++; fails++;
            $display("FAIL R4 unexpected frame: got start bit expected idle line");
            mon_byte = 8'h00;
         end else mon_byte = tx_exp.pop_front();
         mon_active = 1; mon_err = 0; mon_k = 1;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, fails);
         $finish;
      end
   end

   initial begin
      int f0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check("R1", "tx idle", {31'h0, tx_o}, 32'h1);
      check("R1", "irq low", {31'h0, irq_o}, 32'h0);
      rd_check("R1", "txctrl", A_TXC, 32'h0);
      rd_check("R1", "rxctrl", A_RXC, 32'h0);
      rd_check("R1", "ie", A_IE, 32'h0);
      rd_check("R1", "ip", A_IP, 32'h0);
      rd_check("R13", "div reset", A_DIV, 32'd15);
      rd_check("R5", "empty read", A_RXD, 32'h8000_0000);

      // R2/R4: fill while disabled, one extra write dropped
      for (int i = 0; i < 8; i++) tx_put(8'h11 * (i + 1) ^ 8'h5A, 1);
      rd_check("R2", "txdata full flag", A_TXD, 32'h8000_0000);
      tx_put(8'h99, 0);
      repeat (400) @(negedge clk);
      check("R4", "nothing sent while disabled", tx_exp.size(), 8);
      bus_write(A_TXC, 32'h0001_0000);
      rd_check("R9", "ip tx level 8 count 1", A_IP, 32'h0);
      f0 = frames_done;
      bus_write(A_TXC, 32'h0001_0001);
      repeat (8 * 161 + 60) @(negedge clk);
      check("R2", "eight frames, overflow byte dropped", frames_done - f0, 8);
      check("R4", "queue drained in order", tx_exp.size(), 0);
      rd_check("R2", "txdata not full", A_TXD, 32'h0);
      rd_check("R9", "ip tx empty count 1", A_IP, 32'h1);

      // R12 masking
      bus_write(A_IE, 32'h1);
      check("R12", "irq tx enabled", {31'h0, irq_o}, 32'h1);
      bus_write(A_IE, 32'h2);
      check("R12", "irq masked", {31'h0, irq_o}, 32'h0);

      // R3 two stop bits
      bus_write(A_TXC, 32'h0001_0003);
      mon_nbits = 11;
      f0 = frames_done;
      tx_put(8'hA5, 1);
      tx_put(8'h3C, 1);
      repeat (2 * 177 + 40) @(negedge clk);
      check("R3", "two stop-bit frames", frames_done - f0, 2);

      // R13 divisor width and R3 at short bit time
      bus_write(A_DIV, 32'hFFFF_0009);
      rd_check("R13", "div upper bits dropped", A_DIV, 32'h0000_0009);
      bus_write(A_DIV, 32'd4);
      cur_div = 4;
      bus_write(A_TXC, 32'h0001_0001);
      mon_nbits = 10;
      f0 = frames_done;
      tx_put(8'h5A, 1);
      repeat (80) @(negedge clk);
      check("R3", "frame at div 4", frames_done - f0, 1);
      bus_write(A_DIV, 32'd15);
      cur_div = 15;

      // R6 receiver disabled
      send_rx(8'h42, 1);
      rx_pop_check("R6");

      // R5/R10 count 0
      bus_write(A_RXC, 32'h0000_0001);
      rx_en_m = 1;
      send_rx(8'hC3, 1);
      rd_check("R10", "ip rx count 0 one byte", A_IP, 32'h3);
      rx_pop_check("R5");
      rx_pop_check("R5");
      rd_check("R10", "ip after pop", A_IP, 32'h1);

      // R10 count 2
      bus_write(A_RXC, 32'h0002_0001);
      send_rx(8'h01, 1);
      send_rx(8'h80, 1);
      rd_check("R10", "ip rx level 2 count 2", A_IP, 32'h1);
      send_rx(8'hE7, 1);
      rd_check("R10", "ip rx level 3 count 2", A_IP, 32'h3);
      for (int i = 0; i < 3; i++) rx_pop_check("R5");

      // R8 overflow
      for (int i = 0; i < 9; i++) send_rx(8'h30 + 8'(i), 1);
      for (int i = 0; i < 9; i++) rx_pop_check("R8");

      // R7 glitch and low stop bit
      @(negedge clk) rx_line = 0;
      @(negedge clk) rx_line = 1;
      repeat (60) @(negedge clk);
      rx_pop_check("R7");
      send_rx(8'h66, 0);
      rx_pop_check("R7");
      send_rx(8'h77, 1);
      rx_pop_check("R7");

      // R11 read-only pending
      bus_write(A_IP, 32'hFFFF_FFFF);
      rd_check("R11", "ip unchanged by write", A_IP, 32'h1);
      bus_write(A_IE, 32'h3);
      rd_check("R11", "ie readback", A_IE, 32'h3);

      // R12 receive interrupt
      bus_write(A_RXC, 32'h0000_0001);
      bus_write(A_IE, 32'h2);
      send_rx(8'h9B, 1);
      check("R12", "irq rx pending enabled", {31'h0, irq_o}, 32'h1);
      bus_write(A_IE, 32'h0);
      check("R12", "irq all masked", {31'h0, irq_o}, 32'h0);
      rx_pop_check("R5");

      // R9 count 3
      bus_write(A_TXC, 32'h0003_0000);
      tx_put(8'hD2, 1);
      tx_put(8'h2D, 1);
      rd_check("R9", "ip tx level 2 count 3", A_IP, 32'h1);
      tx_put(8'hF0, 1);
      rd_check("R9", "ip tx level 3 count 3", A_IP, 32'h0);
      f0 = frames_done;
      bus_write(A_TXC, 32'h0003_0001);
      repeat (3 * 161 + 60) @(negedge clk);
      check("R4", "frames after enable", frames_done - f0, 3);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, fails);
      $finish;
   end

endmodule